// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync Burst

The block accepts a 10-bit parallel word once per reference period and sends it on one serial line as a 12-bit frame. Each frame opens with a high start bit and closes with a low stop bit, so the line always toggles at least once per frame. Everything runs on one fast clock. A bit-rate enable pulses twelve times per reference period. The reference clock arrives as a level input sampled on that fast clock, and a select input chooses whether its rising or its falling edge strobes the parallel word.

Two sync-request inputs are ORed together. A request that stays high for six consecutive reference edges starts a burst of 1024 sync frames. Once a burst is running, the request inputs are ignored until the burst has completed. If the request is still high when the last frame of the burst completes, sync frames keep going until it drops. When power-down is released, the block spends 32 reference edges in initialization with its output off, and only then starts sending data frames. The high-impedance output state is modelled by a valid flag. This flag is low in initialization, in power-down, and whenever the output-enable input is low.

Top module: `ser_framed_tx`

## Requirements
- R1: Every frame is 12 bit-enable slots long. Bits go out in this order: start bit (1), data bits 0 to 9 (LSB first), stop bit (0). Frame slots are counted from the release of power-down.
- R2: When `edge_sel_i` is 1, `data_i` is captured on the rising edge of `ref_clk_i`. When it is 0, `data_i` is captured on the falling edge. Later frames carry the captured word.
- R3: The request is `sync_a_i | sync_b_i`. It must be seen high on six consecutive selected reference edges before a burst starts. Any edge that sees it low restarts the count.
- R4: A burst sends exactly 1024 consecutive sync frames. A sync frame carries payload bits 9..5 = 1 and bits 4..0 = 0 (10'h3E0).
- R5: Once a burst has started, changes on the request inputs do not shorten it and do not extend it.
- R6: If the request is high when the 1024th sync frame completes, sync frames continue until a frame boundary sees the request low. Data frames follow after that.
- R7: While `en_i` is 0, `ser_valid_o` and `ser_o` are 0.
- R8: While `pwrdn_ni` is 0, `ser_valid_o` and `ser_o` are 0. Power-down clears the mode, the counters and any burst in progress.
- R9: After `pwrdn_ni` rises, the output stays off for 32 selected reference edges (initialization). Data frames are sent after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Bit-rate enable, twelve pulses per reference period |
| ref_clk_i | input | 1 | Reference clock level, sampled on clk_i |
| edge_sel_i | input | 1 | 1: capture on the rising reference edge, 0: capture on the falling reference edge |
| data_i | input | 10 | Parallel data word |
| sync_a_i | input | 1 | Sync request, first input |
| sync_b_i | input | 1 | Sync request, second input |
| en_i | input | 1 | Output enable |
| pwrdn_ni | input | 1 | Active-low power-down |
| ser_o | output | 1 | Serial line, 0 when not valid |
| ser_valid_o | output | 1 | Output driven (low models high impedance) |

## Verification
The bound checker watches properties that hold on every cycle. Every frame carries its start bit in slot 0 and its stop bit in slot 11. The mode leaves data transmission for a burst only after six qualifying edges with the request high. The burst counter never passes 1024, and a burst cannot end early. Sync mode exits only with the burst complete and the request low. Power-down always returns the block to initialization. The bench scenarios check what a single cycle cannot show: the count of sync frames in each run, which word each capture edge takes, rejection of a request one edge too short, the continued-sync run length, the 32-edge initialization gap, and the clearing of a burst by power-down.

// File: rtl/ser_framed_pkg.sv
package ser_framed_pkg;
  typedef enum logic [1:0] {
    M_INIT = 2'd0,
    M_DATA = 2'd1,
    M_SYNC = 2'd2
  } mode_t;
endpackage

// File: rtl/ser_edge_capture.sv
module ser_edge_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_ni,
  input  logic              ref_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tick_o,
  output logic [DATA_W-1:0] word_o
);
  logic ref_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_clk_i;

  assign tick_o = edge_sel_i ? (ref_clk_i & ~ref_q) : (~ref_clk_i & ref_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        word_o <= '0;
    else if (!pwrdn_ni) word_o <= '0;
    else if (tick_o)    word_o <= data_i;
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_framed_pkg::*;
#(
  parameter int INIT_TICKS   = 32,
  parameter int QUAL_TICKS   = 6,
  parameter int BURST_FRAMES = 1024,
  localparam int INIT_W  = $clog2(INIT_TICKS + 1),
  localparam int QUAL_W  = $clog2(QUAL_TICKS + 1),
  localparam int BURST_W = $clog2(BURST_FRAMES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrdn_ni,
  input  logic               tick_i,
  input  logic               req_i,
  input  logic               frame_done_i,
  output mode_t              mode_o,
  output logic               send_sync_o,
  output logic [QUAL_W-1:0]  qual_cnt_o,
  output logic [BURST_W-1:0] burst_cnt_o
);
  logic [INIT_W-1:0] init_cnt;
  logic              burst_open;

  assign burst_open  = burst_cnt_o < BURST_W'(BURST_FRAMES);
  // decision for the frame loaded in this cycle
  assign send_sync_o = (mode_o == M_SYNC) && (burst_open || req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= M_INIT;
      init_cnt    <= '0;
      qual_cnt_o  <= '0;
      burst_cnt_o <= '0;
    end else if (!pwrdn_ni) begin
      mode_o      <= M_INIT;
      init_cnt    <= '0;
      qual_cnt_o  <= '0;
      burst_cnt_o <= '0;
    end else begin
      case (mode_o)
        M_INIT: if (tick_i) begin
          if (init_cnt == INIT_W'(INIT_TICKS - 1)) begin
            mode_o   <= M_DATA;
            init_cnt <= '0;
          end else begin
            init_cnt <= init_cnt + 1'b1;
          end
        end
        M_DATA: if (tick_i) begin
          if (!req_i) begin
            qual_cnt_o <= '0;
          end else if (qual_cnt_o == QUAL_W'(QUAL_TICKS - 1)) begin
            mode_o      <= M_SYNC;
            qual_cnt_o  <= '0;
            burst_cnt_o <= '0;
          end else begin
            qual_cnt_o <= qual_cnt_o + 1'b1;
          end
        end
        M_SYNC: if (frame_done_i) begin
          if (burst_open)  burst_cnt_o <= burst_cnt_o + 1'b1;
          else if (!req_i) mode_o      <= M_DATA;
        end
        default: mode_o <= M_INIT;
      endcase
    end
  end
endmodule

// File: rtl/ser_frame_shift.sv
module ser_frame_shift #(
  parameter int DATA_W = 10,
  parameter logic [DATA_W-1:0] SYNC_WORD = ~({DATA_W{1'b1}} >> (DATA_W / 2)),
  localparam int FRAME_W = DATA_W + 2,
  localparam int PTR_W   = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwrdn_ni,
  input  logic              bit_en_i,
  input  logic              send_sync_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ser_bit_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              frame_done_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [DATA_W-1:0]  payload;

  assign payload      = send_sync_i ? SYNC_WORD : word_i;
  assign frame_done_o = pwrdn_ni & bit_en_i & (ptr_o == LAST);
  assign ser_bit_o    = shreg[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      shreg <= {1'b0, {DATA_W{1'b0}}, 1'b1};
    end else if (!pwrdn_ni) begin
      ptr_o <= '0;
      shreg <= {1'b0, {DATA_W{1'b0}}, 1'b1};
    end else if (bit_en_i) begin
      if (ptr_o == LAST) begin
        ptr_o <= '0;
        shreg <= {1'b0, payload, 1'b1};  // stop, payload, start (LSB first)
      end else begin
        ptr_o <= ptr_o + 1'b1;
        shreg <= {1'b0, shreg[FRAME_W-1:1]};
      end
    end
  end
endmodule

// File: rtl/ser_framed_tx.sv
module ser_framed_tx
  import ser_framed_pkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int INIT_TICKS   = 32,
  parameter int QUAL_TICKS   = 6,
  parameter int BURST_FRAMES = 1024,
  parameter logic [DATA_W-1:0] SYNC_WORD = ~({DATA_W{1'b1}} >> (DATA_W / 2)),
  localparam int FRAME_W = DATA_W + 2,
  localparam int PTR_W   = $clog2(FRAME_W),
  localparam int QUAL_W  = $clog2(QUAL_TICKS + 1),
  localparam int BURST_W = $clog2(BURST_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              ref_clk_i,
  input  logic              edge_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              en_i,
  input  logic              pwrdn_ni,
  output logic              ser_o,
  output logic              ser_valid_o
);
  logic               tick;
  logic [DATA_W-1:0]  word;
  logic               req;
  mode_t              mode;
  logic               send_sync;
  logic [QUAL_W-1:0]  qual_cnt;
  logic [BURST_W-1:0] burst_cnt;
  logic               ser_bit;
  logic [PTR_W-1:0]   ptr;
  logic               frame_done;

  assign req = sync_a_i | sync_b_i;

  ser_edge_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .pwrdn_ni, .ref_clk_i, .edge_sel_i, .data_i,
    .tick_o (tick),
    .word_o (word)
  );

  ser_ctrl #(
    .INIT_TICKS(INIT_TICKS), .QUAL_TICKS(QUAL_TICKS), .BURST_FRAMES(BURST_FRAMES)
  ) u_ctrl (
    .clk_i, .rst_ni, .pwrdn_ni,
    .tick_i       (tick),
    .req_i        (req),
    .frame_done_i (frame_done),
    .mode_o       (mode),
    .send_sync_o  (send_sync),
    .qual_cnt_o   (qual_cnt),
    .burst_cnt_o  (burst_cnt)
  );

  ser_frame_shift #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_shift (
    .clk_i, .rst_ni, .pwrdn_ni, .bit_en_i,
    .send_sync_i  (send_sync),
    .word_i       (word),
    .ser_bit_o    (ser_bit),
    .ptr_o        (ptr),
    .frame_done_o (frame_done)
  );

  assign ser_valid_o = en_i & pwrdn_ni & (mode != M_INIT);
  assign ser_o       = ser_valid_o & ser_bit;
endmodule

// File: rtl/ser_framed_tx_chk.sv
module ser_framed_tx_chk
  import ser_framed_pkg::*;
#(
  parameter int FRAME_W      = 12,
  parameter int QUAL_TICKS   = 6,
  parameter int BURST_FRAMES = 1024,
  localparam int PTR_W   = $clog2(FRAME_W),
  localparam int QUAL_W  = $clog2(QUAL_TICKS + 1),
  localparam int BURST_W = $clog2(BURST_FRAMES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwrdn_ni,
  input logic               req,
  input mode_t              mode,
  input logic [QUAL_W-1:0]  qual_cnt,
  input logic [BURST_W-1:0] burst_cnt,
  input logic [PTR_W-1:0]   ptr,
  input logic               ser_o,
  input logic               ser_valid_o
);
  a_r1_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_valid_o && ptr == '0) |-> ser_o);

  a_r1_stop_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr == PTR_W'(FRAME_W - 1)) |-> !ser_o);

  a_r3_qualified_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_SYNC && $past(mode) == M_DATA)
      |-> ($past(req) && $past(qual_cnt) == QUAL_W'(QUAL_TICKS - 1)));

  a_r4_burst_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_cnt <= BURST_W'(BURST_FRAMES));

  a_r5_burst_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_ni && mode == M_SYNC && burst_cnt < BURST_W'(BURST_FRAMES))
      |=> (mode == M_SYNC));

  a_r6_sync_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_DATA && $past(mode) == M_SYNC)
      |-> (!$past(req) && $past(burst_cnt) == BURST_W'(BURST_FRAMES)));

  a_r8_pd_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwrdn_ni |=> (mode == M_INIT && burst_cnt == '0 && !ser_valid_o));
endmodule

bind ser_framed_tx ser_framed_tx_chk #(
  .FRAME_W(FRAME_W), .QUAL_TICKS(QUAL_TICKS), .BURST_FRAMES(BURST_FRAMES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwrdn_ni    (pwrdn_ni),
  .req         (req),
  .mode        (mode),
  .qual_cnt    (qual_cnt),
  .burst_cnt   (burst_cnt),
  .ptr         (ptr),
  .ser_o       (ser_o),
  .ser_valid_o (ser_valid_o)
);

// File: tb/sim_ser_framed_tx.sv
`timescale 1ns/1ps
module sim_ser_framed_tx;
  localparam int PER = 24;  // clk cycles per reference period
  localparam logic [9:0] SYNC_PL = 10'h3E0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, ref_clk = 1'b0, edge_sel = 1'b1;
  logic [9:0] data = '0;
  logic sync_a = 1'b0, sync_b = 1'b0, en = 1'b1, pwrdn_n = 1'b0;
  logic ser, ser_valid;

  logic [9:0] word_a = 10'h2B5;
  logic [9:0] word_b = 10'h14A;

  int cyc = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // frame monitor state
  int bcnt = 0, sync_run = 0, last_run = 0, runs_seen = 0, frame_err = 0, nframes = 0;
  bit frame_ok = 1'b1;
  logic [11:0] fbits = '0, last_frame = '0;

  always #2 clk = ~clk;

  ser_framed_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .ref_clk_i(ref_clk),
    .edge_sel_i(edge_sel), .data_i(data), .sync_a_i(sync_a), .sync_b_i(sync_b),
    .en_i(en), .pwrdn_ni(pwrdn_n), .ser_o(ser), .ser_valid_o(ser_valid)
  );

  // reference, bit enable and data pattern: word_a around rising, word_b around falling
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      ref_clk = (cyc % PER) < PER / 2;
      bit_en  = (cyc % 2) == 0;
      data    = ((cyc % PER) >= 6 && (cyc % PER) < 18) ? word_b : word_a;
    end
  end

  always @(negedge clk) begin
    if (!pwrdn_n) begin
      bcnt = 0; sync_run = 0; frame_ok = 1'b1;
    end else if (bit_en) begin
      int idx;
      idx = bcnt % 12;
      if (idx == 0) begin frame_ok = 1'b1; fbits = '0; end
      fbits[idx] = ser;
      if (!ser_valid) frame_ok = 1'b0;
      if (idx == 11 && frame_ok) begin
        nframes++;
        last_frame = fbits;
        if (fbits[0] !== 1'b1 || fbits[11] !== 1'b0) frame_err++;
        if (fbits[10:1] == SYNC_PL) sync_run++;
        else begin
          if (sync_run > 0) begin last_run = sync_run; runs_seen++; end
          sync_run = 0;
        end
      end
      bcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic periods(input int n);
    repeat (n * PER) @(posedge clk);
    #2;
  endtask

  task automatic align();
    do begin @(posedge clk); #2; end while (cyc % PER != 1);
  endtask

  task automatic wait_run(input int r0, input int lim);
    int k = 0;
    while (runs_seen == r0 && k < lim * PER) begin @(posedge clk); k++; end
    #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ser_valid == 1'b0, "R8 valid in reset/power-down", ser_valid, 0);
    chk(ser == 1'b0, "R8 ser in power-down", ser, 0);
  endtask

  task automatic t_init();
    align();
    pwrdn_n = 1'b1;
    periods(30);
    chk(ser_valid == 1'b0, "R9 off during init", ser_valid, 0);
    periods(4);
    chk(ser_valid == 1'b1, "R9 on after 32 edges", ser_valid, 1);
  endtask

  task automatic t_edges();
    edge_sel = 1'b1;
    periods(4);
    chk(last_frame[10:1] == word_a, "R2 rising-edge capture", last_frame[10:1], word_a);
    chk(last_frame[0] == 1'b1 && last_frame[11] == 1'b0, "R1 start/stop bits",
        last_frame, {1'b0, word_a, 1'b1});
    edge_sel = 1'b0;
    periods(4);
    chk(last_frame[10:1] == word_b, "R2 falling-edge capture", last_frame[10:1], word_b);
    edge_sel = 1'b1;
    word_a = 10'h0C3;
    periods(4);
    chk(last_frame[10:1] == word_a, "R1 LSB-first payload", last_frame[10:1], word_a);
  endtask

  task automatic t_short_req();
    int r0 = runs_seen;
    align();
    sync_a = 1'b1; periods(5); sync_a = 1'b0;
    periods(1);
    sync_b = 1'b1; periods(3); sync_b = 1'b0;
    periods(1);
    sync_a = 1'b1; periods(4); sync_a = 1'b0;
    periods(3);
    chk(sync_run == 0 && runs_seen == r0, "R3 five edges do not qualify", sync_run, 0);
  endtask

  task automatic t_burst();
    int r0 = runs_seen;
    align();
    sync_b = 1'b1; periods(6); sync_b = 1'b0;
    periods(20);
    chk(sync_run > 0, "R3 six edges on second input start burst", sync_run, 1);
    sync_a = 1'b1; periods(8); sync_a = 1'b0;   // R5 toggling mid-burst
    periods(3);
    sync_b = 1'b1; periods(2); sync_b = 1'b0;
    wait_run(r0, 1100);
    chk(last_run == 1024, "R4 burst length", last_run, 1024);
    chk(runs_seen == r0 + 1, "R5 single unaltered burst", runs_seen, r0 + 1);
    periods(3);
    chk(last_frame[10:1] == word_a && sync_run == 0, "R6 data resumes after burst",
        last_frame[10:1], word_a);
  endtask

  task automatic t_held_req();
    int r0 = runs_seen;
    align();
    sync_a = 1'b1; periods(1100); sync_a = 1'b0;
    wait_run(r0, 50);
    chk(last_run > 1024, "R6 sync continues while held", last_run, 1025);
    chk(last_run >= 1090 && last_run <= 1098, "R6 sync stops when released", last_run, 1094);
    periods(3);
    chk(last_frame[10:1] == word_a, "R6 data after continued sync", last_frame[10:1], word_a);
  endtask

  task automatic t_enable();
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(ser_valid == 1'b0, "R7 enable low turns output off", ser_valid, 0);
    chk(ser == 1'b0, "R7 ser low while disabled", ser, 0);
    en = 1'b1;
    @(negedge clk);
    chk(ser_valid == 1'b1, "R7 enable restores output", ser_valid, 1);
  endtask

  task automatic t_pwrdn();
    align();
    sync_a = 1'b1; periods(6); sync_a = 1'b0;
    periods(50);
    chk(sync_run > 0, "R8 burst active before power-down", sync_run, 1);
    pwrdn_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(ser_valid == 1'b0 && ser == 1'b0, "R8 power-down turns output off", ser_valid, 0);
    periods(3);
    align();
    pwrdn_n = 1'b1;
    periods(20);
    chk(ser_valid == 1'b0, "R9 re-init keeps output off", ser_valid, 0);
    periods(20);
    chk(ser_valid == 1'b1, "R9 output on after re-init", ser_valid, 1);
    periods(3);
    chk(sync_run == 0 && last_frame[10:1] == word_a, "R8 burst cleared by power-down",
        sync_run, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    t_reset();
    t_init();
    t_edges();
    t_short_req();
    t_burst();
    t_held_req();
    t_enable();
    t_pwrdn();
    chk(frame_err == 0, "R1 all frames framed", frame_err, 0);
    chk(nframes > 2000, "R1 frames observed", nframes, 2000);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule